// File: doc/BRIEF.md
# Boost Overvoltage Hysteresis Supervisor

This block decides, on every system clock, whether the boost converter phases may switch. Two comparators report the output voltage against a trip level and a lower release level. Crossing the trip level stops switching at once. Switching resumes only after the output has dropped below the release level. The gap between the two levels gives the loop hysteresis, so it does not chatter around a single threshold.

The block also guards the gate-driver supply. An undervoltage comparator is ignored while the supply settles after power-on. After that it must stay asserted for a fixed qualification time before it stops the converter. A 3-bit threshold code of zero turns this guard off.

Three status outputs are provided. A sticky overvoltage flag records that a trip happened and is cleared by a status read. A per-phase status vector shows whether each phase is free of an overvoltage hold.

Top module: `boost_ov_supervisor`

## Requirements
- R1: While porN is low, and directly after it is released, pwmEnable is 1, every phaseOk bit is 1 and ovFlag is 0.
- R2: A clock edge that samples ovHigh=1 makes pwmEnable 0, all phaseOk bits 0 and ovFlag 1 after that edge.
- R3: Once tripped, switching stays off while ovLow=0, even after ovHigh has returned to 0.
- R4: An edge that samples ovLow=1 with ovHigh=0 while tripped makes pwmEnable 1 and all phaseOk bits 1 after that edge.
- R5: ovFlag stays 1 after a trip until an edge samples statusRead=1 together with ovLow=1 and ovHigh=0, which clears it. A read sampled while ovLow=0 leaves it at 1.
- R6: When ovHigh=1 and statusRead=1 are sampled on the same edge, ovFlag is 1 after that edge (set wins).
- R7: uvCmp is ignored for the first BLANK_CYCLES clock edges after porN rises.
- R8: With uvThrCode equal to 3'b000, uvCmp never stops switching. Any nonzero code enables the guard.
- R9: Once blanking is over, pwmEnable falls after the UV_QUAL_CYCLES-th consecutive edge that samples uvCmp=1 with a nonzero code. A single edge sampling uvCmp=0 restarts the count.
- R10: An undervoltage shutdown ends combinationally, in the same cycle that uvCmp falls or the code becomes 3'b000, with no clock edge needed.
- R11: An undervoltage shutdown changes neither phaseOk nor ovFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz nominal) |
| porN | input | 1 | Active-low power-on reset; its release starts the undervoltage blanking |
| ovHigh | input | 1 | Comparator: output above the shutdown level |
| ovLow | input | 1 | Comparator: output below shutdown level minus release offset |
| uvCmp | input | 1 | Comparator: gate-driver supply below its threshold |
| uvThrCode | input | 3 | Undervoltage threshold code; 3'b000 disables the guard |
| statusRead | input | 1 | One-cycle strobe marking a status read |
| pwmEnable | output | 1 | 1 when the boost phases may switch |
| phaseOk | output | NUM_PHASES | Per-phase status, 0 while an overvoltage hold is active |
| ovFlag | output | 1 | Sticky overvoltage flag |

## Verification
The assertions check the following on every cycle:
- an overvoltage sample always produces the trip state;
- a trip is held until the release strobe;
- the flag falls only on a qualified read;
- undervoltage shutdown never appears during blanking, with a zero code, or while the comparator is low.

Some behaviour depends on timing, and only the bench scenarios show it:
- the exact edge at which the qualification count completes, counted from reset;
- the restart after a one-cycle dropout;
- the interplay of trip, release and read over long input sequences.

// File: rtl/boost_ov_supervisor_pkg.sv
package boost_ov_supervisor_pkg;
  localparam int unsigned UV_CODE_W = 3;

  typedef struct packed {
    logic ovSet;
    logic ovRelease;
    logic flagClear;
    logic uvShut;
  } supStrobes_t;
endpackage

// File: rtl/boost_ov_sup_ctrl.sv
module boost_ov_sup_ctrl
  import boost_ov_supervisor_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES   = 1500,
  parameter int unsigned UV_QUAL_CYCLES = 200
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 ovHigh,
  input  logic                 ovLow,
  input  logic                 uvCmp,
  input  logic [UV_CODE_W-1:0] uvThrCode,
  input  logic                 statusRead,
  output supStrobes_t          strobes
);
  localparam int unsigned BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam int unsigned QUAL_W  = $clog2(UV_QUAL_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_END = BLANK_W'(BLANK_CYCLES);
  localparam logic [QUAL_W-1:0]  QUAL_LAST = QUAL_W'(UV_QUAL_CYCLES - 1);

  logic [BLANK_W-1:0] blankCnt;
  logic               blankDone;
  logic [QUAL_W-1:0]  qualCnt;
  logic               uvTrip;
  logic               uvActive;
  logic               recovered;

  assign blankDone = (blankCnt == BLANK_END);
  assign uvActive  = blankDone && (uvThrCode != '0) && uvCmp;
  assign recovered = ovLow && !ovHigh;

  // Count edges after power-on release until blanking ends
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      blankCnt <= '0;
    end else if (!blankDone) begin
      blankCnt <= blankCnt + 1'b1;
    end
  end

  // Qualify a persistent undervoltage; any gap restarts the count
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      qualCnt <= '0;
      uvTrip  <= 1'b0;
    end else if (!uvActive) begin
      qualCnt <= '0;
      uvTrip  <= 1'b0;
    end else if (!uvTrip) begin
      if (qualCnt == QUAL_LAST) begin
        uvTrip <= 1'b1;
      end else begin
        qualCnt <= qualCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.ovSet     = ovHigh;
    strobes.ovRelease = recovered;
    strobes.flagClear = statusRead && recovered;
    strobes.uvShut    = uvTrip && uvActive;
  end

  // R7
  blank_gate_chk: assert property (@(posedge clk) disable iff (!porN)
    !blankDone |-> !strobes.uvShut);

  // R8
  code_off_chk: assert property (@(posedge clk) disable iff (!porN)
    (uvThrCode == '0) |-> !strobes.uvShut);

  // R10
  uv_release_chk: assert property (@(posedge clk) disable iff (!porN)
    !uvCmp |-> !strobes.uvShut);

  // R9
  uv_qual_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(strobes.uvShut) |-> $past(uvCmp));
endmodule

// File: rtl/boost_ov_sup_datapath.sv
module boost_ov_sup_datapath
  import boost_ov_supervisor_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 3
) (
  input  logic                  clk,
  input  logic                  porN,
  input  supStrobes_t           strobes,
  output logic                  pwmEnable,
  output logic [NUM_PHASES-1:0] phaseOk,
  output logic                  ovFlag
);
  logic ovActive;

  // Hysteretic trip state: set on trip, cleared only on release
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ovActive <= 1'b0;
    end else if (strobes.ovSet) begin
      ovActive <= 1'b1;
    end else if (strobes.ovRelease) begin
      ovActive <= 1'b0;
    end
  end

  // Sticky flag; set has priority over a qualified read
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ovFlag <= 1'b0;
    end else if (strobes.ovSet) begin
      ovFlag <= 1'b1;
    end else if (strobes.flagClear) begin
      ovFlag <= 1'b0;
    end
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    assign phaseOk[p] = !ovActive;
  end

  assign pwmEnable = !ovActive && !strobes.uvShut;

  // R2
  ov_set_chk: assert property (@(posedge clk) disable iff (!porN)
    strobes.ovSet |=> (ovFlag && (phaseOk == '0) && !pwmEnable));

  // R3
  ov_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    ((phaseOk == '0) && !strobes.ovRelease) |=> (phaseOk == '0));

  // R4
  ov_release_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobes.ovRelease && !strobes.ovSet) |=> (&phaseOk));

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(ovFlag) |-> $past(strobes.flagClear));
endmodule

// File: rtl/boost_ov_supervisor.sv
module boost_ov_supervisor
  import boost_ov_supervisor_pkg::*;
#(
  parameter int unsigned NUM_PHASES     = 3,
  parameter int unsigned BLANK_CYCLES   = 1500,
  parameter int unsigned UV_QUAL_CYCLES = 200
) (
  input  logic                  clk,
  input  logic                  porN,
  input  logic                  ovHigh,
  input  logic                  ovLow,
  input  logic                  uvCmp,
  input  logic [2:0]            uvThrCode,
  input  logic                  statusRead,
  output logic                  pwmEnable,
  output logic [NUM_PHASES-1:0] phaseOk,
  output logic                  ovFlag
);
  supStrobes_t strobes;

  boost_ov_sup_ctrl #(
    .BLANK_CYCLES  (BLANK_CYCLES),
    .UV_QUAL_CYCLES(UV_QUAL_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .ovHigh    (ovHigh),
    .ovLow     (ovLow),
    .uvCmp     (uvCmp),
    .uvThrCode (uvThrCode),
    .statusRead(statusRead),
    .strobes   (strobes)
  );

  boost_ov_sup_datapath #(
    .NUM_PHASES(NUM_PHASES)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .strobes  (strobes),
    .pwmEnable(pwmEnable),
    .phaseOk  (phaseOk),
    .ovFlag   (ovFlag)
  );

  // R11
  uv_no_status_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobes.uvShut && !strobes.ovSet) |=> ($stable(ovFlag) || !ovFlag));
endmodule

// File: tb/boost_ov_supervisor_test.sv
module boost_ov_supervisor_test;
  localparam int PH    = 3;
  localparam int BLANK = 40;
  localparam int QUAL  = 8;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          ovHigh = 1'b0, ovLow = 1'b0, uvCmp = 1'b0, statusRead = 1'b0;
  logic [2:0]    uvThrCode = 3'd3;
  logic          pwmEnable, ovFlag;
  logic [PH-1:0] phaseOk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  boost_ov_supervisor #(
    .NUM_PHASES(PH), .BLANK_CYCLES(BLANK), .UV_QUAL_CYCLES(QUAL)
  ) uut (
    .clk(clk), .porN(porN), .ovHigh(ovHigh), .ovLow(ovLow), .uvCmp(uvCmp),
    .uvThrCode(uvThrCode), .statusRead(statusRead),
    .pwmEnable(pwmEnable), .phaseOk(phaseOk), .ovFlag(ovFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic checkAll(input string tag, input bit pwm, input bit ok, input bit flag);
    check({tag, " pwmEnable"}, int'(pwmEnable), int'(pwm));
    check({tag, " phaseOk"}, int'(phaseOk), ok ? (1 << PH) - 1 : 0);
    check({tag, " ovFlag"}, int'(ovFlag), int'(flag));
  endtask

  initial begin
    bit expAct;
    bit expFlag;
    string tag;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 in reset", 1'b1, 1'b1, 1'b0);
    porN = 1'b1;
    uvCmp = 1'b1;
    #1;
    checkAll("R1 after release", 1'b1, 1'b1, 1'b0);

    // R7 and R9: blanking, then qualification
    for (int e = 1; e < BLANK + QUAL; e++) begin
      step();
      check("R7 blanked or qualifying", int'(pwmEnable), 1);
    end
    step();
    check("R9 qualified shutdown", int'(pwmEnable), 0);
    check("R11 phaseOk unaffected", int'(phaseOk), (1 << PH) - 1);
    check("R11 ovFlag unaffected", int'(ovFlag), 0);
    uvCmp = 1'b0;
    #1;
    check("R10 immediate release", int'(pwmEnable), 1);
    step();

    // R9: a one-edge dropout restarts the count
    uvCmp = 1'b1;
    repeat (QUAL - 1) step();
    check("R9 before dropout", int'(pwmEnable), 1);
    uvCmp = 1'b0;
    step();
    uvCmp = 1'b1;
    repeat (QUAL - 1) step();
    check("R9 count restarted", int'(pwmEnable), 1);
    step();
    check("R9 after restart", int'(pwmEnable), 0);

    // R8 and R10: code zero releases at once and keeps the guard off
    uvThrCode = 3'd0;
    #1;
    check("R10 code zero release", int'(pwmEnable), 1);
    for (int k = 0; k < 3 * QUAL; k++) begin
      step();
      check("R8 code zero ignored", int'(pwmEnable), 1);
    end
    uvCmp = 1'b0;
    step();

    // R9: sweep all nonzero codes
    for (int c = 1; c < 8; c++) begin
      uvThrCode = 3'(c);
      uvCmp = 1'b1;
      repeat (QUAL - 1) step();
      check("R9 code sweep early", int'(pwmEnable), 1);
      step();
      check("R9 code sweep trip", int'(pwmEnable), 0);
      uvCmp = 1'b0;
      step();
      check("R10 code sweep release", int'(pwmEnable), 1);
    end

    // R2..R6: overvoltage input sweep against an arithmetic model
    expAct = 1'b0;
    expFlag = 1'b0;
    for (int i = 0; i < 512; i++) begin
      int v;
      bit hi;
      bit lo;
      bit rd;
      v  = (i * 13 + (i >> 3) * 7) % 29;
      hi = (v % 7) == 0;
      lo = (v % 3) == 0;
      rd = ((i >> 1) % 3) == 0;
      ovHigh = hi;
      ovLow = lo;
      statusRead = rd;
      if (hi && rd) tag = "R6";
      else if (hi) tag = "R2";
      else if (expAct && lo) tag = "R4";
      else if (expAct) tag = "R3";
      else tag = "R5";
      if (hi) begin
        expAct = 1'b1;
        expFlag = 1'b1;
      end else if (lo) begin
        expAct = 1'b0;
        if (rd) expFlag = 1'b0;
      end
      step();
      checkAll(tag, !expAct, !expAct, expFlag);
    end

    // R5: a read while still above the release level keeps the flag
    ovHigh = 1'b1;
    ovLow = 1'b0;
    statusRead = 1'b0;
    step();
    ovHigh = 1'b0;
    statusRead = 1'b1;
    step();
    checkAll("R5 read during fault", 1'b0, 1'b0, 1'b1);
    statusRead = 1'b0;
    ovLow = 1'b1;
    step();
    checkAll("R5 released, flag kept", 1'b1, 1'b1, 1'b1);
    statusRead = 1'b1;
    step();
    checkAll("R5 qualified read clears", 1'b1, 1'b1, 1'b0);
    statusRead = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule